// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt events for a small 8-bit processor core, picks the most urgent one and hands the core a 16-bit vector address. There are seventeen priority levels. Level 1 is a reset slot that is presented once after every reset. Levels 2 to 16 are fifteen maskable slots, each with a request latch and an enable bit. Level 17 is a software break that no mask can block. Five external pins pass through a two-flop synchronizer and an edge detector whose direction is programmable. Twelve internal event lines come from other on-chip functions. Two slots are shared between two sources, and a select bit decides which source drives the slot.

When the core acknowledges, the block clears the request it was presenting. One cycle later it pulses an output that tells the core to raise its own interrupt-disable flag. Saving the program counter and the status register is left to the core. Software reaches the enables, the requests and a control register over a simple byte-wide register port. Software can only clear requests and can never set them. Rewriting a polarity bit or a source-select bit can itself set a request, because the edge detector sees the change of its input.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq` is 1 with `vec_addr` = 0xFFFC (the reset slot, level 1), whatever the value of `idis`. An acknowledge retires the reset slot.
- R2: A maskable slot is presented only when its request bit is 1, its enable bit is 1 and `idis` is 0. A request with its enable bit at 0, or with `idis` at 1, leaves `irq` at 0.
- R3: Slot s (0 to 14) is priority level s+2, and a lower level wins. The vector for level L is 0xFFFC - 2*(L-1), so slot 0 gives 0xFFFA and slot 3 gives 0xFFF4.
- R4: A pulse on `brk_req` produces level 17 (vector 0xFFDC). It is taken even when `idis` is 1 and every enable bit is 0, and it loses to any presentable maskable slot.
- R5: Register map. Address 0 holds the enables of slots 7..0 and address 1 holds the enables of slots 14..8 in bits 6..0. Address 2 holds the requests of slots 7..0 and address 3 holds the requests of slots 14..8. Address 4 is the control register: polarity bits 4..0, one per external pin, and select bits 6..5. A write to a request register clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R6: When a hardware set and a clear of the same request bit fall in the same cycle, the bit ends up set.
- R7: An acknowledge while `irq` is 1 clears the serviced request. `irq` reads 0 in the next cycle and `idis_set` is 1 for that one cycle. An acknowledge while `irq` is 0 has no effect.
- R8: External pins 0, 1 and 2 drive slots 0, 1 and 2, pin 3 drives slot 12, and pin 4 drives slot 13. Polarity bit 0 selects a rising edge and 1 selects a falling edge. Each edge in the selected direction sets exactly one request, and an edge in the other direction sets none.
- R9: Changing a polarity bit while the pin is steady is treated as an edge. Setting the polarity bit to falling while the pin is low sets that slot's request.
- R10: Internal event k (0 to 8) drives slot 3+k on its rising level. Slot 13 takes pin 4 when select bit 5 is 0 and event 9 when it is 1. Slot 14 takes event 10 when select bit 6 is 0 and event 11 when it is 1. A source that is not selected sets nothing, and switching the select onto a source that is already high sets the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 5 | Asynchronous external interrupt pins |
| evt_in | input | 12 | Synchronous internal event lines |
| brk_req | input | 1 | Software break request pulse |
| idis | input | 1 | Core's global interrupt-disable flag |
| irq_ack | input | 1 | Core acknowledge of the presented vector |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt presented to the core |
| vec_addr | output | 16 | Low-byte address of the presented vector pair |
| idis_set | output | 1 | One-cycle pulse: core must set its disable flag |

## Verification
A hardware event can set a request latch in the same cycle that a bus write clears it. The bench provokes this by raising an internal event in the very cycle that it writes zeros to the request register, and then expects the bit to read back as 1. Quirk sets also land in the same cycle as register writes: a polarity write or a select write sets a request with no pin activity at all. Each of these cases is judged both by reading the request register back and by the vector the scoreboard pops when the slot is acknowledged.

// File: rtl/pic_pkg.sv
// Shared constants, register addresses and the level-to-vector mapping
// of the interrupt controller. Assumes a fixed source-to-slot map.
package pic_pkg;
    localparam int NUM_EXT   = 5;
    localparam int NUM_SLOT  = 15;
    localparam int NUM_EVT   = 12;
    localparam int NUM_SEL   = 2;
    localparam int NUM_INT   = 9;           // plain internal slots 3..11
    localparam int LVL_W     = 5;
    localparam int VEC_W     = 16;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 3;
    localparam int LVL_RESET = 1;
    localparam int LVL_FIRST = 2;
    localparam int LVL_BRK   = NUM_SLOT + LVL_FIRST;
    localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFC;

    typedef enum logic [ADDR_W-1:0] {
        RA_EN_LO = 3'd0,
        RA_EN_HI = 3'd1,
        RA_RQ_LO = 3'd2,
        RA_RQ_HI = 3'd3,
        RA_CTRL  = 3'd4
    } reg_addr_e;

    // Vector low-byte address for a priority level: two bytes per level.
    function automatic logic [VEC_W-1:0] lvl_to_vec(input logic [LVL_W-1:0] lvl);
        logic [LVL_W:0] off;
        off = {lvl - LVL_W'(1), 1'b0};
        return VEC_TOP - VEC_W'(off);
    endfunction
endpackage

// File: rtl/pic_edge_sync.sv
// Synchronizes asynchronous pins with two flops and applies a per-pin
// polarity. The output is high when the pin sits in its active direction,
// so a polarity flip on a steady pin looks like a level change downstream.
module pic_edge_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    input  logic [W-1:0] pol_fall,
    output logic [W-1:0] eff
);
    logic [W-1:0] s1_q, s2_q;

    // Two-stage synchronizer for metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= pin;
            s2_q <= s1_q;
        end
    end

    // Polarity: a falling-edge pin is inverted so that its active edge rises.
    assign eff = s2_q ^ pol_fall;
endmodule

// File: rtl/pic_req_bank.sv
// Request latches with rising-edge set detection per slot. A set beats a
// clear in the same cycle. Assumes the clear vector is already decoded.
module pic_req_bank #(
    parameter int N = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] clr,
    output logic [N-1:0] req
);
    logic [N-1:0] trig_q, set_v, req_q;

    // Remember last trigger level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= '0;
        else        trig_q <= trig;
    end

    assign set_v = trig & ~trig_q;

    // Latch update: clear first, then hardware set on top.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= (req_q & ~clr) | set_v;
    end

    assign req = req_q;

    AST_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((req_q & ~$past(req_q) & ~$past(set_v)) == '0)); // R5
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v != '0) |=> ((req_q & $past(set_v)) == $past(set_v))); // R6
endmodule

// File: rtl/pic_prio.sv
// Combinational priority resolver. The reset slot comes first, then the
// lowest pending maskable slot when not disabled, then the software break.
module pic_prio #(
    parameter int N     = 15,
    parameter int LW    = 5,
    parameter int FIRST = 2,
    parameter int BRK   = 17
) (
    input  logic [N-1:0]  pend,
    input  logic          idis,
    input  logic          brk,
    input  logic          rst_pend,
    output logic          found,
    output logic [LW-1:0] lvl
);
    // Pick the winning level; a descending scan leaves the lowest index.
    always_comb begin
        found = 1'b0;
        lvl   = '0;
        if (rst_pend) begin
            found = 1'b1;
            lvl   = LW'(1);
        end else if (!idis && (pend != '0)) begin
            found = 1'b1;
            for (int s = N - 1; s >= 0; s--) begin
                if (pend[s]) lvl = LW'(s + FIRST);
            end
        end else if (brk) begin
            found = 1'b1;
            lvl   = LW'(BRK);
        end
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Top of the prioritized vectored interrupt controller. Holds the enable
// and control registers, maps the sources onto slots, registers the
// presented vector and handles the acknowledge. Assumes the core raises
// its own disable flag when idis_set pulses.
module irq_vector_ctrl
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EXT-1:0] ext_pin,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic              brk_req,
    input  logic              idis,
    input  logic              irq_ack,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic [VEC_W-1:0]  vec_addr,
    output logic              idis_set
);
    localparam int HI_W = NUM_SLOT - DATA_W;

    logic [NUM_SLOT-1:0] en_q, req, trig, clr;
    logic [NUM_EXT-1:0]  pol_q, eff;
    logic [NUM_SEL-1:0]  sel_q;
    logic                brk_q, rst_pend_q, irq_q, idis_set_q, found, ack_hit;
    logic [LVL_W-1:0]    lvl, lvl_q;
    logic [VEC_W-1:0]    vec_q;

    assign ack_hit = irq_ack & irq_q;

    pic_edge_sync #(.W(NUM_EXT)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin), .pol_fall(pol_q), .eff(eff)
    );

    // Source-to-slot map, including the two shared slots.
    always_comb begin
        trig     = '0;
        trig[0]  = eff[0];
        trig[1]  = eff[1];
        trig[2]  = eff[2];
        for (int k = 0; k < NUM_INT; k++) trig[3 + k] = evt_in[k];
        trig[12] = eff[3];
        trig[13] = sel_q[0] ? evt_in[9]  : eff[4];
        trig[14] = sel_q[1] ? evt_in[11] : evt_in[10];
    end

    // Clear sources: bus writes of 0 to request bits and the acknowledge.
    always_comb begin
        clr = '0;
        if (bus_we && reg_addr_e'(bus_addr) == RA_RQ_LO) clr[DATA_W-1:0] = ~bus_wdata;
        if (bus_we && reg_addr_e'(bus_addr) == RA_RQ_HI) clr[NUM_SLOT-1:DATA_W] = ~bus_wdata[HI_W-1:0];
        for (int s = 0; s < NUM_SLOT; s++) begin
            if (ack_hit && lvl_q == LVL_W'(s + LVL_FIRST)) clr[s] = 1'b1;
        end
    end

    pic_req_bank #(.N(NUM_SLOT)) u_req (
        .clk(clk), .rst_n(rst_n), .trig(trig), .clr(clr), .req(req)
    );

    pic_prio #(.N(NUM_SLOT), .LW(LVL_W), .FIRST(LVL_FIRST), .BRK(LVL_BRK)) u_prio (
        .pend(req & en_q), .idis(idis), .brk(brk_q), .rst_pend(rst_pend_q),
        .found(found), .lvl(lvl)
    );

    // Software-writable enable and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            pol_q <= '0;
            sel_q <= '0;
        end else if (bus_we) begin
            case (reg_addr_e'(bus_addr))
                RA_EN_LO: en_q[DATA_W-1:0]        <= bus_wdata;
                RA_EN_HI: en_q[NUM_SLOT-1:DATA_W] <= bus_wdata[HI_W-1:0];
                RA_CTRL: begin
                    pol_q <= bus_wdata[NUM_EXT-1:0];
                    sel_q <= bus_wdata[NUM_EXT +: NUM_SEL];
                end
                default: ;
            endcase
        end
    end

    // Register read multiplexer.
    always_comb begin
        case (reg_addr_e'(bus_addr))
            RA_EN_LO: bus_rdata = en_q[DATA_W-1:0];
            RA_EN_HI: bus_rdata = {1'b0, en_q[NUM_SLOT-1:DATA_W]};
            RA_RQ_LO: bus_rdata = req[DATA_W-1:0];
            RA_RQ_HI: bus_rdata = {1'b0, req[NUM_SLOT-1:DATA_W]};
            RA_CTRL:  bus_rdata = {1'b0, sel_q, pol_q};
            default:  bus_rdata = '0;
        endcase
    end

    // Break and reset-slot pending flags; a new break beats its own clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            brk_q      <= 1'b0;
            rst_pend_q <= 1'b1;
        end else begin
            brk_q <= (brk_q & ~(ack_hit && lvl_q == LVL_W'(LVL_BRK))) | brk_req;
            if (ack_hit && lvl_q == LVL_W'(LVL_RESET)) rst_pend_q <= 1'b0;
        end
    end

    // Presented vector: refreshed every cycle, dropped for one cycle on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q      <= 1'b0;
            lvl_q      <= '0;
            vec_q      <= '0;
            idis_set_q <= 1'b0;
        end else begin
            irq_q      <= found & ~ack_hit;
            lvl_q      <= lvl;
            vec_q      <= found ? lvl_to_vec(lvl) : '0;
            idis_set_q <= ack_hit;
        end
    end

    assign irq      = irq_q;
    assign vec_addr = vec_q;
    assign idis_set = idis_set_q;

    AST_IRQ_DROP_ON_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq) |=> !irq); // R7
    AST_IDIS_SET_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq) |=> idis_set); // R7
    AST_NO_IDIS_SET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack && irq) |=> !idis_set); // R7
    AST_BRK_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_q && !irq_ack) |=> irq); // R4
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idis && !brk_q && !rst_pend_q) |=> !irq); // R2
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  ext_pin = '0;
    logic [11:0] evt_in = '0;
    logic        brk_req = 1'b0, idis = 1'b1, irq_ack = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq, idis_set;
    logic [15:0] vec_addr;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    event        ack_ev;
    bit          done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .evt_in(evt_in),
        .brk_req(brk_req), .idis(idis), .irq_ack(irq_ack), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .vec_addr(vec_addr), .idis_set(idis_set)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the expected vector whenever the driver acknowledges.
    initial forever begin
        @(ack_ev);
        if (exp_q.size() == 0) check("scoreboard empty", 16'h1, 16'h0);
        else check(tag_q.pop_front(), vec_addr, exp_q.pop_front());
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1 check(tag, {8'h0, bus_rdata}, {8'h0, exp});
    endtask

    // Driver: queue the expected vector, wait for irq, then acknowledge.
    task automatic service(input logic [15:0] exp, input string tag);
        int t = 0;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        while (!irq && t < 30) begin @(negedge clk); t++; end
        if (!irq) begin
            check({tag, " irq never raised"}, 16'h0, 16'h1);
            void'(exp_q.pop_back());
            void'(tag_q.pop_back());
        end else begin
            irq_ack = 1'b1;
            -> ack_ev;
            @(negedge clk);
            irq_ack = 1'b0;
            check({tag, " R7 irq after ack"}, {15'h0, irq}, 16'h0);
            check({tag, " R7 idis_set"}, {15'h0, idis_set}, 16'h1);
        end
    endtask

    task automatic pulse_evt(input int k);
        @(negedge clk); evt_in[k] = 1'b1;
        @(negedge clk); evt_in[k] = 1'b0;
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset irq", {15'h0, irq}, 16'h1);
        check("R1 reset vec", vec_addr, 16'hFFFC);
        bus_rd(3'd0, 8'h00, "R1 EN_LO");
        bus_rd(3'd1, 8'h00, "R1 EN_HI");
        bus_rd(3'd2, 8'h00, "R1 RQ_LO");
        bus_rd(3'd3, 8'h00, "R1 RQ_HI");
        bus_rd(3'd4, 8'h00, "R1 CTRL");
        service(16'hFFFC, "R1 reset slot with idis=1");
        idis = 1'b0;

        // R2: masked by enable, then by idis, then taken.
        pulse_evt(0);
        wait_cyc(2);
        check("R2 enable off", {15'h0, irq}, 16'h0);
        bus_rd(3'd2, 8'h08, "R2 request latched");
        idis = 1'b1;
        bus_wr(3'd0, 8'h08);
        wait_cyc(2);
        check("R2 idis set", {15'h0, irq}, 16'h0);
        idis = 1'b0;
        service(16'hFFF4, "R2 slot3");
        bus_rd(3'd2, 8'h00, "R7 serviced request cleared");

        // R3/R4: three pending at once, resolved in order.
        idis = 1'b1;
        pulse_evt(2);
        pulse_evt(0);
        @(negedge clk); brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
        bus_wr(3'd0, 8'h28);
        idis = 1'b0;
        service(16'hFFF4, "R3 first slot3");
        service(16'hFFF0, "R3 second slot5");
        service(16'hFFDC, "R4 break last");

        // R4: break with everything masked.
        bus_wr(3'd0, 8'h00);
        idis = 1'b1;
        @(negedge clk); brk_req = 1'b1;
        @(negedge clk); brk_req = 1'b0;
        service(16'hFFDC, "R4 break unmasked");

        // R5: software can clear but not set.
        bus_wr(3'd2, 8'hFF);
        bus_rd(3'd2, 8'h00, "R5 write 1 sets nothing");
        pulse_evt(1);
        bus_rd(3'd2, 8'h10, "R5 hw set");
        bus_wr(3'd2, 8'hFF);
        bus_rd(3'd2, 8'h10, "R5 write 1 keeps");
        bus_wr(3'd2, 8'hEF);
        bus_rd(3'd2, 8'h00, "R5 write 0 clears");
        bus_wr(3'd3, 8'h7F);
        bus_rd(3'd3, 8'h00, "R5 hi write 1 sets nothing");

        // R6: set and clear in the same cycle.
        @(negedge clk);
        evt_in[3] = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h00;
        @(negedge clk);
        evt_in[3] = 1'b0; bus_we = 1'b0;
        bus_rd(3'd2, 8'h40, "R6 hw set wins");
        bus_wr(3'd2, 8'hBF);

        // R7: ack while idle is ignored.
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
        check("R7 idle ack no idis_set", {15'h0, idis_set}, 16'h0);

        // R8: rising edge on pin 0.
        idis = 1'b0;
        bus_wr(3'd0, 8'h07);
        @(negedge clk); ext_pin[0] = 1'b1;
        service(16'hFFFA, "R8 pin0 rise");
        wait_cyc(5);
        check("R8 steady high no retrigger", {15'h0, irq}, 16'h0);
        ext_pin[0] = 1'b0;
        wait_cyc(5);
        bus_rd(3'd2, 8'h00, "R8 wrong edge ignored");

        // R9: polarity flip on a steady low pin sets a request.
        bus_wr(3'd4, 8'h02);
        service(16'hFFF8, "R9 polarity flip");
        @(negedge clk); ext_pin[1] = 1'b1;
        wait_cyc(5);
        bus_rd(3'd2, 8'h00, "R8 rise ignored when falling set");
        @(negedge clk); ext_pin[1] = 1'b0;
        service(16'hFFF8, "R8 pin1 fall");

        // R10: shared slot 13.
        bus_wr(3'd1, 8'h20);
        @(negedge clk); evt_in[9] = 1'b1;
        wait_cyc(4);
        bus_rd(3'd3, 8'h00, "R10 unselected source ignored");
        bus_wr(3'd4, 8'h22);
        service(16'hFFE0, "R10 select switch sets");
        @(negedge clk); evt_in[9] = 1'b0;
        pulse_evt(9);
        service(16'hFFE0, "R10 selected event");
        bus_wr(3'd4, 8'h02);
        wait_cyc(4);
        bus_rd(3'd3, 8'h00, "R10 switch back to low pin");

        wait_cyc(2);
        if (exp_q.size() != 0) check("scoreboard leftover", 16'(exp_q.size()), 16'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule